// File: doc/BRIEF.md
# Register-Mapped Serial Port with Level Watermarks

This block is a byte-wide asynchronous serial port attached to a 32-bit word-register bus. Software queues outgoing bytes into an eight-entry transmit queue and drains incoming bytes from an eight-entry receive queue. Each of the two data registers reports whether it can be used in bit 31 of the read value: "queue full" for transmit and "queue empty" for receive. A receive data read that finds a byte also removes it from the queue.

Two control words switch the transmitter and receiver on, select one or two stop bits, and hold a watermark level for each queue. The two pending flags are compared against the queue occupancies on every cycle and are never latched. An enable word masks them onto one interrupt line. A divisor word sets the bit period directly in clock cycles. The receiver decides each bit from three samples taken around its middle.

Top module: `wmark_uart`

## Requirements
- R1: After reset the line output is high and the interrupt is low. The control words, the interrupt enable and the pending word read 0, the divisor reads 15, the transmit data word reads 0, and the receive data word reads 0x8000_0000.
- R2: A transmit data read returns bit 31 set exactly when eight bytes are queued. A write to word 0 while the queue is full is dropped and never transmitted.
- R3: A receive data read (word 1) with bytes queued returns the oldest byte in bits 7:0 and 0 in bits 31:8, then removes that byte. With the queue empty it returns 0x8000_0000.
- R4: Each frame is a low start bit, then 8 data bits least significant first, then stop bits at high level. Every bit lasts divisor+1 cycles. Transmit control bit 1 = 0 gives one stop bit and 1 gives two.
- R5: While transmit control bit 0 is 0, no frame starts and the line stays high.
- R6: While receive control bit 0 is 0, received frames are discarded.
- R7: Pending bit 0 is 1 when the transmit occupancy is less than the transmit level (word 2 bits 19:16). With level 1 it is 1 exactly when the transmit queue is empty.
- R8: Pending bit 1 is 1 when the receive occupancy is greater than the receive level (word 3 bits 19:16).
- R9: The interrupt output is high exactly when some pending bit is 1 and its enable bit (word 4 bits 1:0) is 1.
- R10: A frame that completes while eight bytes are waiting in the receive queue is discarded, and the queued bytes are unchanged.
- R11: The receiver takes the majority of three samples around mid-bit. A low pulse that is high at the middle of its start bit is rejected. A one-cycle glitch within a bit does not change the received byte.
- R12: Word offsets are 0 transmit data, 1 receive data, 2 transmit control, 3 receive control, 4 interrupt enable, 5 pending (read-only), 6 divisor (bits 15:0). Unimplemented bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq | output | 1 | Masked watermark interrupt |
| txd | output | 1 | Serial line out |
| rxd | input | 1 | Serial line in |

## Verification
On every cycle, the assertions check the following:
- A full queue ignores pushes.
- An occupancy never exceeds the depth.
- A disabled transmitter stays idle.
- A disabled receiver never pushes.
- A masked interrupt stays low.
- Pending bit 0 tracks the transmit queue being empty when the level is 1.

Only the bench scenarios can show the following:
- The serial frame shape and the stop-bit count.
- The byte order through both queues.
- Dropping of the ninth byte on both sides.
- Rejection of a short false start, and recovery of a byte through a mid-bit glitch.

// File: rtl/wmark_uart_pkg.sv
package wmark_uart_pkg;

    localparam logic [2:0] A_TXDATA = 3'd0;
    localparam logic [2:0] A_RXDATA = 3'd1;
    localparam logic [2:0] A_TXCTRL = 3'd2;
    localparam logic [2:0] A_RXCTRL = 3'd3;
    localparam logic [2:0] A_IE     = 3'd4;
    localparam logic [2:0] A_IP     = 3'd5;
    localparam logic [2:0] A_DIV    = 3'd6;

    localparam int LVL_LSB = 16;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_START,
        SER_DATA,
        SER_STOP
    } ser_state_e;

endpackage

// File: rtl/wmark_fifo.sv
module wmark_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          do_push, do_pop;

    assign full_o  = (st_q.count == CW'(DEPTH));
    assign empty_o = (st_q.count == '0);
    assign head_o  = mem_q[st_q.rd];
    assign count_o = st_q.count;

    always_comb begin
        st_d    = st_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) st_d.wr = st_q.wr + AW'(1);
        if (do_pop)  st_d.rd = st_q.rd + AW'(1);
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + CW'(1);
            2'b01:   st_d.count = st_q.count - CW'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= wdata_i;
    end

    // R2 / R10: a push into a full queue leaves the occupancy untouched
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> (count_o == $past(count_o)));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

endmodule

// File: rtl/wmark_tx.sv
module wmark_tx
    import wmark_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             two_stop_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             avail_i,
    input  logic [7:0]       byte_i,
    output logic             pop_o,
    output logic             txd_o
);

    typedef struct packed {
        ser_state_e       st;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bitn;
        logic             extra_stop;
        logic [7:0]       shreg;
        logic             line;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   bit_end;

    assign txd_o   = st_q.line;
    assign bit_end = (st_q.cnt == div_i);

    always_comb begin
        st_d  = st_q;
        pop_o = 1'b0;
        if (st_q.st != SER_IDLE)
            st_d.cnt = bit_end ? '0 : st_q.cnt + DIV_W'(1);
        case (st_q.st)
            SER_IDLE: begin
                st_d.line = 1'b1;
                if (en_i && avail_i) begin
                    pop_o      = 1'b1;
                    st_d.shreg = byte_i;
                    st_d.cnt   = '0;
                    st_d.line  = 1'b0;
                    st_d.st    = SER_START;
                end
            end
            SER_START: if (bit_end) begin
                st_d.st   = SER_DATA;
                st_d.bitn = '0;
                st_d.line = st_q.shreg[0];
            end
            SER_DATA: if (bit_end) begin
                if (st_q.bitn == 3'd7) begin
                    st_d.st         = SER_STOP;
                    st_d.line       = 1'b1;
                    st_d.extra_stop = two_stop_i;
                end else begin
                    st_d.bitn  = st_q.bitn + 3'd1;
                    st_d.shreg = st_q.shreg >> 1;
                    st_d.line  = st_q.shreg[1];
                end
            end
            default: if (bit_end) begin
                if (st_q.extra_stop) st_d.extra_stop = 1'b0;
                else                 st_d.st         = SER_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.st   <= SER_IDLE;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a disabled transmitter never leaves idle
    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == SER_IDLE && !en_i) |=> (st_q.st == SER_IDLE));

    // R4: the line is high whenever no frame is in flight
    p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == SER_IDLE) |-> txd_o);

endmodule

// File: rtl/wmark_rx.sv
module wmark_rx
    import wmark_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             rxd_i,
    output logic             push_o,
    output logic [7:0]       byte_o
);

    typedef struct packed {
        logic [1:0]       sync;
        ser_state_e       st;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bitn;
        logic [2:0]       votes;
        logic [7:0]       shreg;
    } rx_st_t;

    rx_st_t           st_d, st_q;
    logic             line, vote, bit_end, in_window;
    logic [DIV_W-1:0] mid;

    assign line      = st_q.sync[1];
    assign mid       = div_i >> 1;
    assign bit_end   = (st_q.cnt == div_i);
    assign in_window = (st_q.cnt == mid - DIV_W'(1)) || (st_q.cnt == mid) ||
                       (st_q.cnt == mid + DIV_W'(1));
    assign vote      = (st_q.votes[0] & st_q.votes[1]) | (st_q.votes[1] & st_q.votes[2]) |
                       (st_q.votes[0] & st_q.votes[2]);
    assign byte_o    = st_q.shreg;

    always_comb begin
        st_d      = st_q;
        push_o    = 1'b0;
        st_d.sync = {st_q.sync[0], rxd_i};
        if (st_q.st != SER_IDLE) begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
            if (in_window) st_d.votes = {st_q.votes[1:0], line};
        end
        case (st_q.st)
            SER_IDLE: if (!line) begin
                st_d.st    = SER_START;
                st_d.cnt   = '0;
                st_d.votes = '0;
            end
            SER_START: if (bit_end) begin
                st_d.cnt  = '0;
                st_d.bitn = '0;
                st_d.st   = vote ? SER_IDLE : SER_DATA;
            end
            SER_DATA: if (bit_end) begin
                st_d.cnt   = '0;
                st_d.shreg = {vote, st_q.shreg[7:1]};
                st_d.bitn  = st_q.bitn + 3'd1;
                if (st_q.bitn == 3'd7) st_d.st = SER_STOP;
            end
            default: if (st_q.cnt == mid + DIV_W'(2)) begin
                st_d.st = SER_IDLE;
                push_o  = vote && en_i;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.st   <= SER_IDLE;
            st_q.sync <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: nothing is delivered while reception is off
    p_push_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> en_i);

    // R11: a start bit judged high returns the receiver to idle
    p_false_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == SER_START && bit_end && vote) |=> (st_q.st == SER_IDLE));

endmodule

// File: rtl/wmark_uart.sv
module wmark_uart
    import wmark_uart_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 15,
    localparam int CNT_W    = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        txd,
    input  logic        rxd
);

    typedef struct packed {
        logic             tx_en;
        logic             two_stop;
        logic [CNT_W-1:0] tx_lvl;
        logic             rx_en;
        logic [CNT_W-1:0] rx_lvl;
        logic [1:0]       ie;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t            reg_d, reg_q;
    logic             wr, rd;
    logic             tx_push, tx_pop, tx_full, tx_empty;
    logic             rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic [1:0]       pend;

    assign wr      = bus_sel && bus_we;
    assign rd      = bus_sel && !bus_we;
    assign tx_push = wr && (bus_addr == A_TXDATA);
    assign rx_pop  = rd && (bus_addr == A_RXDATA);
    assign pend    = {rx_count > reg_q.rx_lvl, tx_count < reg_q.tx_lvl};
    assign irq     = |(pend & reg_q.ie);

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[31:LVL_LSB+CNT_W], bus_wdata[LVL_LSB-1:DIV_W]};

    always_comb begin
        reg_d = reg_q;
        if (wr) begin
            case (bus_addr)
                A_TXCTRL: begin
                    reg_d.tx_en    = bus_wdata[0];
                    reg_d.two_stop = bus_wdata[1];
                    reg_d.tx_lvl   = bus_wdata[LVL_LSB +: CNT_W];
                end
                A_RXCTRL: begin
                    reg_d.rx_en  = bus_wdata[0];
                    reg_d.rx_lvl = bus_wdata[LVL_LSB +: CNT_W];
                end
                A_IE:    reg_d.ie  = bus_wdata[1:0];
                A_DIV:   reg_d.div = bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_TXDATA: bus_rdata[31] = tx_full;
            A_RXDATA: bus_rdata = rx_empty ? 32'h8000_0000 : {24'd0, rx_head};
            A_TXCTRL: begin
                bus_rdata[LVL_LSB +: CNT_W] = reg_q.tx_lvl;
                bus_rdata[1:0]              = {reg_q.two_stop, reg_q.tx_en};
            end
            A_RXCTRL: begin
                bus_rdata[LVL_LSB +: CNT_W] = reg_q.rx_lvl;
                bus_rdata[0]                = reg_q.rx_en;
            end
            A_IE:     bus_rdata[1:0]       = reg_q.ie;
            A_IP:     bus_rdata[1:0]       = pend;
            A_DIV:    bus_rdata[DIV_W-1:0] = reg_q.div;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q     <= '0;
            reg_q.div <= DIV_W'(DIV_RESET);
        end else begin
            reg_q <= reg_d;
        end
    end

    wmark_fifo #(.W(8), .DEPTH(DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push_i(tx_push), .wdata_i(bus_wdata[7:0]),
        .pop_i(tx_pop), .head_o(tx_head), .count_o(tx_count),
        .full_o(tx_full), .empty_o(tx_empty)
    );

    wmark_fifo #(.W(8), .DEPTH(DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .push_i(rx_push), .wdata_i(rx_byte),
        .pop_i(rx_pop), .head_o(rx_head), .count_o(rx_count),
        .full_o(rx_full), .empty_o(rx_empty)
    );

    wmark_tx #(.DIV_W(DIV_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .en_i(reg_q.tx_en), .two_stop_i(reg_q.two_stop),
        .div_i(reg_q.div), .avail_i(!tx_empty), .byte_i(tx_head),
        .pop_o(tx_pop), .txd_o(txd)
    );

    wmark_rx #(.DIV_W(DIV_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .en_i(reg_q.rx_en), .div_i(reg_q.div),
        .rxd_i(rxd), .push_o(rx_push), .byte_o(rx_byte)
    );

    // R9: with every enable clear the interrupt stays low
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.ie == 2'b00) |-> !irq);

    // R7: level 1 makes the transmit flag mean "queue drained"
    p_txwm_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.tx_lvl == CNT_W'(1)) |-> (pend[0] == tx_empty));

    // R10: a byte arriving at a full receive queue is dropped
    p_rx_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push && !rx_pop) |=> (rx_count == CNT_W'(DEPTH)));

endmodule

// File: tb/wmark_uart_tb_top.sv
module wmark_uart_tb_top;
    import wmark_uart_pkg::*;

    localparam int BITP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, txd, rxd;
    logic        loop = 1'b1, rxd_drv = 1'b1;
    int          checks = 0, fails = 0, decoded = 0;
    bit          stop_two = 1'b0;
    logic [7:0]  txq[$];

    always #10 clk = ~clk;
    assign rxd = loop ? txd : rxd_drv;

    wmark_uart dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .txd(txd), .rxd(rxd)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_tx_empty();
        logic [31:0] v;
        for (int k = 0; k < 4000; k++) begin
            rd(A_IP, v);
            if (v[0]) break;
        end
        repeat (12 * BITP) @(negedge clk);
    endtask

    task automatic send_line(logic [7:0] b, int gbit, int gcyc);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++)
            for (int c = 0; c < BITP; c++) begin
                @(negedge clk);
                rxd_drv = (i == gbit && c == gcyc) ? ~fr[i] : fr[i];
            end
        @(negedge clk);
        rxd_drv = 1'b1;
    endtask

    function automatic logic [7:0] pat(int i);
        return 8'(i * 53 + 7);
    endfunction

    // behavioural line decoder: checks frame shape (R4) against the queued bytes
    initial begin
        logic [7:0] got;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                repeat (BITP / 2) @(negedge clk);
                chk("R4 start bit", 32'(txd), 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITP) @(negedge clk);
                    got[i] = txd;
                end
                repeat (BITP) @(negedge clk);
                chk("R4 stop bit", 32'(txd), 32'd1);
                if (stop_two) begin
                    repeat (BITP) @(negedge clk);
                    chk("R4 second stop bit", 32'(txd), 32'd1);
                end
                if (txq.size() == 0) chk("R4 unexpected frame", 32'(got), 32'hxx);
                else chk("R4 frame byte", 32'(got), 32'(txq.pop_front()));
                decoded++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int lows;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 txd", 32'(txd), 1); chk("R1 irq", 32'(irq), 0);
        rd(A_TXCTRL, v); chk("R1 txctrl", v, 0);
        rd(A_RXCTRL, v); chk("R1 rxctrl", v, 0);
        rd(A_IE, v);     chk("R1 ie", v, 0);
        rd(A_IP, v);     chk("R1 ip", v, 0);
        rd(A_DIV, v);    chk("R1 div", v, 15);
        rd(A_TXDATA, v); chk("R1 txdata", v, 0);
        rd(A_RXDATA, v); chk("R1 rxdata", v, 32'h8000_0000);

        // R12 field layout and unused bits
        wr(A_TXCTRL, 32'h0003_FFFF); rd(A_TXCTRL, v); chk("R12 txctrl", v, 32'h0003_0003);
        wr(A_RXCTRL, 32'hFFF5_FFFF); rd(A_RXCTRL, v); chk("R12 rxctrl", v, 32'h0005_0001);
        wr(A_IE, 32'hFFFF_FFFF);     rd(A_IE, v);     chk("R12 ie", v, 3);
        wr(A_IE, 0);
        wr(A_DIV, 32'hFFFF_000F);    rd(A_DIV, v);    chk("R12 div", v, 15);
        wr(A_IP, 32'hFFFF_FFFF);

        // R2 / R5 / R7: fill with transmitter off
        wr(A_TXCTRL, 32'h0001_0000);
        rd(A_IP, v); chk("R7 empty tx flag", v & 1, 1);
        for (int i = 0; i < 8; i++) begin
            wr(A_TXDATA, 32'(pat(i)));
            txq.push_back(pat(i));
        end
        rd(A_TXDATA, v); chk("R2 full flag", v, 32'h8000_0000);
        rd(A_IP, v);     chk("R7 flag low when queued", v & 1, 0);
        wr(A_TXDATA, 32'h0000_00EE);
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk("R5 line idle while off", 32'(lows), 0);

        // R4 / R8 / R9 / R3: drain through loopback
        wr(A_RXCTRL, 32'h0007_0001);
        wr(A_TXCTRL, 32'h0001_0001);
        wait_tx_empty();
        chk("R2 frames sent (9th dropped)", 32'(decoded), 8);
        rd(A_IP, v); chk("R8 rx above level", v, 3);
        wr(A_IE, 2); #1 chk("R9 irq rx enabled", 32'(irq), 1);
        wr(A_TXCTRL, 32'h0000_0001);
        wr(A_IE, 1); #1 chk("R9 irq tx masked-off level", 32'(irq), 0);
        wr(A_IE, 0); #1 chk("R9 irq none", 32'(irq), 0);
        wr(A_IE, 2);
        for (int i = 0; i < 8; i++) begin
            rd(A_RXDATA, v); chk("R3 rx byte", v, 32'(pat(i)));
            if (i == 0) begin
                #1 chk("R8 level reached, irq drops", 32'(irq), 0);
            end
        end
        rd(A_RXDATA, v); chk("R3 rx empty after drain", v, 32'h8000_0000);
        wr(A_IE, 0);

        // R4 two stop bits, back-to-back frames
        stop_two = 1'b1;
        wr(A_TXCTRL, 32'h0001_0003);
        for (int i = 0; i < 2; i++) begin
            wr(A_TXDATA, 32'(pat(i + 20)));
            txq.push_back(pat(i + 20));
        end
        wait_tx_empty();
        for (int i = 0; i < 2; i++) begin
            rd(A_RXDATA, v); chk("R4 two-stop byte", v, 32'(pat(i + 20)));
        end
        stop_two = 1'b0;
        wr(A_TXCTRL, 32'h0001_0001);

        // R10 receive overflow
        for (int i = 0; i < 9; i++) begin
            for (int k = 0; k < 2000; k++) begin
                rd(A_TXDATA, v);
                if (!v[31]) break;
            end
            wr(A_TXDATA, 32'(pat(i + 40)));
            txq.push_back(pat(i + 40));
        end
        wait_tx_empty();
        for (int i = 0; i < 8; i++) begin
            rd(A_RXDATA, v); chk("R10 kept byte", v, 32'(pat(i + 40)));
        end
        rd(A_RXDATA, v); chk("R10 ninth discarded", v, 32'h8000_0000);

        // R6 receiver off
        wr(A_RXCTRL, 32'h0000_0000);
        wr(A_TXDATA, 32'h0000_0042); txq.push_back(8'h42);
        wait_tx_empty();
        wr(A_RXCTRL, 32'h0000_0001);
        rd(A_RXDATA, v); chk("R6 discarded while off", v, 32'h8000_0000);

        // R11 false start and glitch
        loop = 1'b0;
        rxd_drv = 1'b1;
        repeat (3) @(negedge clk);
        rxd_drv = 1'b0;
        repeat (3) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (20 * BITP) @(negedge clk);
        rd(A_RXDATA, v); chk("R11 false start rejected", v, 32'h8000_0000);
        send_line(8'hA5, 3, 10);
        repeat (2 * BITP) @(negedge clk);
        rd(A_RXDATA, v); chk("R11 glitch tolerated", v, 32'h0000_00A5);
        send_line(8'h3C, 6, 8);
        repeat (2 * BITP) @(negedge clk);
        rd(A_RXDATA, v); chk("R11 second glitch tolerated", v, 32'h0000_003C);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule